// File: doc/BRIEF.md
# Chained Code-Disjoint Parity Stages

This block is a chain of combinational stages. Each stage takes a data word and one parity bit, and applies a fixed nonlinear mapping to the word to produce its functional outputs. Each stage also drives one extra check bit. That check bit folds two parities into a single line: the parity of the data the stage received, and the parity of the word it produced.

When the stage's parity input is XOR-ed with the check bit, the result is the parity of the outputs. The result is correct only when the incoming word was a valid even-parity codeword. So a fault-free stage turns valid words into valid words and broken words into broken words.

The stages are connected in series: the outputs and recovered parity of one stage become the data and parity inputs of the next. Because errors keep travelling down the chain, one XOR-tree at the far end covers every link. Its result is registered as an error flag.

A fault-injection port can pin one functional output line of any chosen stage to 0 or 1. That line is tapped after the stage has formed its check bit. This lets a system or a bench show that such a defect reaches the final flag.

Top module: `cd_chain_top`

## Requirements
- R1: Each stage maps data x to y with y[i] = x[i] XOR (NOT x[(i+1) mod W] AND x[(i+2) mod W]). With injection off, `dout` equals this mapping applied STAGES times to `din`, and `dout` never depends on `din_par`.
- R2: `dout_chk` equals the XOR of the last stage's functional outputs XOR the XOR of that stage's data inputs.
- R3: `dout_par` equals `dout_chk` XOR the parity bit entering the last stage. When `din_par` equals the XOR of all `din` bits and injection is off, `dout_par` equals the XOR of `dout`.
- R4: An input word whose parity bit differs from the XOR of its data bits yields `err_q` = 1 one clock later. This covers any odd number of flipped bits, the parity bit included.
- R5: A valid input codeword with injection off yields `err_q` = 0 one clock later.
- R6: `err_q` is a register with a synchronous active-low reset. It reads 0 while `rst_n` is low, and afterwards it holds the XOR of `dout` and `dout_par` from the previous clock edge.
- R7: With `flt_en` = 1, functional output bit `flt_bit` of stage `flt_stage` (stage 0 is nearest `din`) is forced to `flt_val`, after that stage's check bit is formed. For a valid input, `err_q` then rises exactly when the forced value differs from the fault-free value. A `flt_bit` of W or more, or `flt_en` = 0, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error flag register |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | W | Data word entering stage 0 |
| din_par | input | 1 | Even-parity bit for `din` |
| flt_en | input | 1 | Enables the stuck-at injection |
| flt_stage | input | SW | Stage index of the injected fault |
| flt_bit | input | BW | Output bit index of the injected fault |
| flt_val | input | 1 | Stuck value forced onto the selected line |
| dout | output | W | Functional outputs of the last stage |
| dout_par | output | 1 | Recovered output parity of the last stage |
| dout_chk | output | 1 | Combined check bit of the last stage |
| err_q | output | 1 | Registered end-of-chain error flag |

## Verification
The end-to-end properties assume that the chain inputs and the injection controls hold steady between rising edges. Faults are assumed to arrive only through the injection port, so the assertions on valid and invalid codewords apply only while `flt_en` is low.

The stimulus changes every input on the falling edge. It holds injection off for the exhaustive sweep over all data and parity values. It turns injection on only in a separate pass, which walks every stage, bit and stuck value over a few valid words, plus out-of-range bit indices.

// File: rtl/cd_pkg.sv
package cd_pkg;
    // Nonlinear bit function shared by every stage: a ^ (~b & c)
    function automatic logic cd_mix(input logic a, input logic b, input logic c);
        return a ^ (~b & c);
    endfunction
endpackage

// File: rtl/cd_stage.sv
// cd_stage: one code-disjoint stage. Produces W functional bits from the data
// word, a check bit (output parity XOR data parity) and the recovered parity
// (check bit XOR incoming parity). Assumes W >= 3 so the mixing taps differ.
module cd_stage #(
    parameter int W = 5
) (
    input  logic [W-1:0] x,
    input  logic         p_in,
    output logic [W-1:0] y_raw,
    output logic         chk,
    output logic         rec
);
    import cd_pkg::*;

    // Functional mapping, one bit per generate iteration
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int I1 = (i + 1) % W;
        localparam int I2 = (i + 2) % W;
        assign y_raw[i] = cd_mix(x[i], x[I1], x[I2]);
    end

    // Merged check bit and recovered output parity
    always_comb begin
        chk = (^y_raw) ^ (^x);
        rec = chk ^ p_in;
    end
endmodule

// File: rtl/cd_fault_tap.sv
// cd_fault_tap: passes a stage's functional bits through, or pins one bit to a
// stuck value when the request names this stage. Indices beyond W never match.
module cd_fault_tap #(
    parameter int W   = 5,
    parameter int SW  = 2,
    parameter int BW  = 3,
    parameter int IDX = 0
) (
    input  logic [W-1:0]  y_raw,
    input  logic          en,
    input  logic [SW-1:0] stage_sel,
    input  logic [BW-1:0] bit_sel,
    input  logic          val,
    output logic [W-1:0]  y
);
    localparam logic [SW-1:0] MY_STAGE = SW'(IDX);

    logic stage_hit;
    assign stage_hit = en && (stage_sel == MY_STAGE);

    // Per-bit override selection
    for (genvar i = 0; i < W; i++) begin : g_tap
        localparam logic [BW-1:0] MY_BIT = BW'(i);
        assign y[i] = (stage_hit && (bit_sel == MY_BIT)) ? val : y_raw[i];
    end
endmodule

// File: rtl/cd_error_reg.sv
// cd_error_reg: final XOR-tree checker over the last stage, registered with a
// synchronous active-low reset.
module cd_error_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] y,
    input  logic         par,
    output logic         err_q
);
    logic mismatch;
    assign mismatch = (^y) ^ par;

    // Capture the parity mismatch each clock
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= mismatch;
    end
endmodule

// File: rtl/cd_chain_top.sv
// cd_chain_top: STAGES code-disjoint stages in series, each followed by a
// fault tap, with one registered checker at the end. Stage j+1 takes stage j's
// tapped outputs as data and its recovered parity as parity input.
module cd_chain_top #(
    parameter int W      = 5,
    parameter int STAGES = 4,
    parameter int SW     = (STAGES > 1) ? $clog2(STAGES) : 1,
    parameter int BW     = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    input  logic          din_par,
    input  logic          flt_en,
    input  logic [SW-1:0] flt_stage,
    input  logic [BW-1:0] flt_bit,
    input  logic          flt_val,
    output logic [W-1:0]  dout,
    output logic          dout_par,
    output logic          dout_chk,
    output logic          err_q
);
    logic [W-1:0] link_x [STAGES+1];
    logic         link_p [STAGES+1];
    logic         stage_chk [STAGES];

    assign link_x[0] = din;
    assign link_p[0] = din_par;

    // Stage chain with a fault tap after each stage
    for (genvar j = 0; j < STAGES; j++) begin : g_stage
        logic [W-1:0] y_raw;
        cd_stage #(.W(W)) u_stage (
            .x     (link_x[j]),
            .p_in  (link_p[j]),
            .y_raw (y_raw),
            .chk   (stage_chk[j]),
            .rec   (link_p[j+1])
        );
        cd_fault_tap #(.W(W), .SW(SW), .BW(BW), .IDX(j)) u_tap (
            .y_raw     (y_raw),
            .en        (flt_en),
            .stage_sel (flt_stage),
            .bit_sel   (flt_bit),
            .val       (flt_val),
            .y         (link_x[j+1])
        );
    end

    assign dout     = link_x[STAGES];
    assign dout_par = link_p[STAGES];
    assign dout_chk = stage_chk[STAGES-1];

    cd_error_reg #(.W(W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .y     (dout),
        .par   (dout_par),
        .err_q (err_q)
    );
endmodule

// File: rtl/cd_chain_checker.sv
// cd_chain_checker: end-to-end properties of the chain, observed at its ports.
// Assumes inputs change only between rising edges.
module cd_chain_checker #(
    parameter int W  = 5,
    parameter int SW = 2,
    parameter int BW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  din,
    input logic          din_par,
    input logic          flt_en,
    input logic [W-1:0]  dout,
    input logic          dout_par,
    input logic          err_q
);
    assert_par_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((^din) == din_par && !flt_en) |-> (dout_par == (^dout)));

    assert_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((^din) != din_par && !flt_en) |=> err_q);

    assert_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((^din) == din_par && !flt_en) |=> !err_q);

    assert_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en |-> (((^dout) ^ dout_par) == ((^din) ^ din_par)));
endmodule

bind cd_chain_top cd_chain_checker #(.W(W), .SW(SW), .BW(BW)) u_cd_chain_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .din_par  (din_par),
    .flt_en   (flt_en),
    .dout     (dout),
    .dout_par (dout_par),
    .err_q    (err_q)
);

// File: tb/cd_chain_top_bench.sv
`timescale 1ns/1ps
module cd_chain_top_bench;
    localparam int W  = 5;
    localparam int K  = 4;
    localparam int SW = 2;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  din = '0;
    logic          din_par = 1'b0;
    logic          flt_en = 1'b0;
    logic [SW-1:0] flt_stage = '0;
    logic [BW-1:0] flt_bit = '0;
    logic          flt_val = 1'b0;
    logic [W-1:0]  dout;
    logic          dout_par, dout_chk, err_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cd_chain_top #(.W(W), .STAGES(K), .SW(SW), .BW(BW)) u_cd_chain_top (
        .clk(clk), .rst_n(rst_n), .din(din), .din_par(din_par),
        .flt_en(flt_en), .flt_stage(flt_stage), .flt_bit(flt_bit), .flt_val(flt_val),
        .dout(dout), .dout_par(dout_par), .dout_chk(dout_chk), .err_q(err_q)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Behavioural model of the requirements; diff is 1 when a stuck value changed a line
    task automatic model(input logic [W-1:0] x0, input logic p0, input logic fen,
                         input int fs, input int fb, input logic fv,
                         output logic [W-1:0] yo, output logic po, output logic co,
                         output logic diff);
        logic [W-1:0] x = x0;
        logic [W-1:0] yr;
        logic p = p0;
        logic c = 1'b0;
        diff = 1'b0;
        for (int s = 0; s < K; s++) begin
            for (int i = 0; i < W; i++)
                yr[i] = x[i] ^ (~x[(i+1)%W] & x[(i+2)%W]);
            c = (^yr) ^ (^x);
            p = c ^ p;
            if (fen && fs == s && fb < W) begin
                diff = yr[fb] ^ fv;
                yr[fb] = fv;
            end
            x = yr;
        end
        yo = x; po = p; co = c;
    endtask

    // Apply one vector and compare combinational outputs and the next flag value
    task automatic apply(input logic [W-1:0] d, input logic p, input logic fen,
                         input int fs, input int fb, input logic fv);
        logic [W-1:0] ey;
        logic ep, ec, diff, ee;
        @(negedge clk);
        din = d; din_par = p; flt_en = fen;
        flt_stage = SW'(fs); flt_bit = BW'(fb); flt_val = fv;
        model(d, p, fen, fs, fb, fv, ey, ep, ec, diff);
        ee = ((^d) ^ p) ^ diff;
        #1;
        check(fen ? "R7 dout" : "R1 dout", dout, ey);
        check("R2 dout_chk", W'(dout_chk), W'(ec));
        check("R3 dout_par", W'(dout_par), W'(ep));
        if (!fen && ((^d) == p)) check("R3 parity of dout", W'(dout_par), W'(^dout));
        @(posedge clk); #1;
        if (fen) check("R7 err_q", W'(err_q), W'(ee));
        else if ((^d) != p) check("R4 err_q", W'(err_q), W'(ee));
        else check("R5 err_q", W'(err_q), W'(ee));
        check("R6 err_q tracks last stage", W'(err_q), W'((^dout) ^ dout_par));
    endtask

    initial begin
        logic [W-1:0] keep;
        // R6: reset holds the flag low
        din = 5'b10110; din_par = 1'b0;
        repeat (3) @(posedge clk);
        #1 check("R6 reset", W'(err_q), '0);
        @(negedge clk); rst_n = 1'b1;

        // Exhaustive sweep: every data word with both parity values (R1, R4, R5)
        for (int d = 0; d < (1 << W); d++) begin
            apply(W'(d), 1'b0, 1'b0, 0, 0, 1'b0);
            keep = dout;
            apply(W'(d), 1'b1, 1'b0, 0, 0, 1'b0);
            check("R1 dout independent of din_par", dout, keep);
        end

        // R4: triple flip including parity bit, from a valid word
        apply(5'b00111 ^ 5'b00011, 1'b1 ^ 1'b1, 1'b0, 0, 0, 1'b0);

        // R7: stuck-at on every stage, bit and value for a few valid words
        for (int v = 0; v < 3; v++) begin
            logic [W-1:0] w;
            w = (v == 0) ? 5'b00000 : (v == 1) ? 5'b10110 : 5'b11101;
            for (int s = 0; s < K; s++)
                for (int b = 0; b < W; b++)
                    for (int fv = 0; fv < 2; fv++)
                        apply(w, ^w, 1'b1, s, b, fv[0]);
        end

        // R7: out-of-range bit index has no effect
        for (int b = W; b < (1 << BW); b++)
            apply(5'b01101, ^5'b01101, 1'b1, 1, b, 1'b1);

        // R7: enable low ignores the request
        apply(5'b01101, ^5'b01101, 1'b0, 1, 2, 1'b0);
        apply(5'b01101, ^5'b01101, 1'b0, 2, 0, 1'b1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule